// File: doc/BRIEF.md
# UART Receive Queue and Status Word Logic

This block sits between the serial shifters of a UART and the register interface that a processor reads. On the receive side it keeps up to two finished characters in a queue. Each queued character carries its own tags: the ninth data bit, a framing-error tag taken from the first stop bit, and a parity-error tag. A third character that completes while the queue is full is held in a single waiting slot, which stands for the receive shift register. It moves into the queue on the same clock edge as the data read that frees an entry. If another start bit is detected while that slot is still occupied, the waiting character is dropped and the overrun flag is raised.

On the transmit side the block holds one character for the transmitter. It reports the holding register's empty state and a transmit-complete flag. It also packs every flag into one 8-bit status word and drives three level-sensitive interrupt requests: receive-complete, data-register-empty and transmit-complete.

Bit layout of the status word, most significant bit first: 7 receive-complete, 6 transmit-complete, 5 data-register-empty, 4 framing error, 3 overrun, 2 parity error, 1 reserved (always 0), 0 ninth received bit.

Top module: `uart_rx_status_regs`

## Requirements
- R1: After reset the status word reads 0x20: only the data-register-empty flag (bit 5) is set. All interrupt requests are low unless the data-register-empty interrupt is enabled.
- R2: A write to the data register loads the holding register and clears bit 5. A `tx_take_i` pulse while the holding register is full sets bit 5 again. When a write and a take fall in the same cycle, the new data stays held and bit 5 stays 0.
- R3: `irq_dre_o` is high in every cycle in which bit 5 is 1 and `dre_ie_i` is 1. It therefore stays high until software writes data or clears the enable.
- R4: Characters are read in arrival order. `rx_data_o` shows bits 7:0 of the oldest unread character, and status bit 0 shows its bit 8. A `data_rd_i` pulse removes that character.
- R5: Status bit 4 is the inverse of the first-stop-bit value captured with the oldest unread character. Each queued character keeps its own value.
- R6: Status bit 2 is the parity-failure tag of the oldest unread character ANDed with `par_en_i`. It reads 0 whenever `par_en_i` is 0.
- R7: A character that completes while the queue is full waits. It becomes the newest queue entry on the same edge as the data read that frees a slot.
- R8: A start-bit strobe while the queue is full and a character is waiting discards the waiting character and sets status bit 3. A data read clears bit 3. A data read in the same cycle as the start strobe takes priority, so no overrun occurs.
- R9: Status bit 7 is 1 whenever at least one unread character is queued. `irq_rxc_o` equals bit 7 ANDed with `rxc_ie_i`.
- R10: `tx_frame_done_i` sets status bit 6. A status write with bit 6 = 1 clears it. `irq_txc_o` equals bit 6 ANDed with `txc_ie_i`.
- R11: A status write with bit 6 = 0 changes no status bit, whatever value the other bits carry. Bit 1 always reads 0.
- R12: A data read while the queue is empty has no effect. The next character received becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_done_i | input | 1 | Character-complete strobe from the receive shifter |
| rx_bits_i | input | 9 | Received data bits, bit 8 is the ninth bit |
| rx_stop1_i | input | 1 | Sampled value of the first stop bit |
| rx_par_bad_i | input | 1 | Parity check failed for this character |
| rx_start_i | input | 1 | Start-bit-detected strobe |
| par_en_i | input | 1 | Parity checking enabled |
| rxc_ie_i | input | 1 | Receive-complete interrupt enable |
| dre_ie_i | input | 1 | Data-register-empty interrupt enable |
| txc_ie_i | input | 1 | Transmit-complete interrupt enable |
| data_rd_i | input | 1 | Read strobe of the low data byte (pops the head) |
| data_wr_i | input | 1 | Write strobe of the data register |
| data_wdata_i | input | 9 | Character written for transmission |
| stat_wr_i | input | 1 | Write strobe of the status word |
| stat_wdata_i | input | 8 | Value written to the status word |
| tx_take_i | input | 1 | Transmit shifter takes the held character |
| tx_frame_done_i | input | 1 | Transmit shifter finished a frame with nothing left to send |
| status_o | output | 8 | Packed status word |
| rx_data_o | output | 8 | Low byte of the oldest unread character |
| tx_hold_o | output | 9 | Character in the transmit holding register |
| tx_hold_valid_o | output | 1 | Holding register contains data |
| irq_rxc_o | output | 1 | Receive-complete interrupt request |
| irq_dre_o | output | 1 | Data-register-empty interrupt request |
| irq_txc_o | output | 1 | Transmit-complete interrupt request |

## Verification
Two pairs of events can land in the same cycle, and both are provoked on purpose. The first pair is a data read and a start-bit strobe while the queue is full and a character is waiting. The bench pulses both on one edge and then expects status bit 3 to stay clear, the second character to be at the head, and the waiting character to follow on the next read. The second pair is a data-register write and a transmitter take. After that edge the bench expects bit 5 to stay 0 and the holding register to show the newly written value.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  localparam int CHAR_W = 9;
  localparam int STAT_W = 8;

  // status word bit positions (software decodes these)
  localparam int ST_RXC  = 7;
  localparam int ST_TXC  = 6;
  localparam int ST_DRE  = 5;
  localparam int ST_FERR = 4;
  localparam int ST_OVR  = 3;
  localparam int ST_PERR = 2;
  localparam int ST_RSVD = 1;
  localparam int ST_BIT8 = 0;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              ferr;
    logic              pbad;
  } rx_entry_t;

endpackage

// File: rtl/rxs_char_queue.sv
module rxs_char_queue
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_i,
  input  rx_entry_t push_ent_i,
  input  logic      start_i,
  input  logic      pop_req_i,
  output rx_entry_t head_o,
  output logic      head_valid_o,
  output logic      ovr_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  rx_entry_t       q_r   [DEPTH];
  rx_entry_t       q_n   [DEPTH];
  logic [CW-1:0]   cnt_r, cnt_n;
  rx_entry_t       wait_r, wait_n;
  logic            wait_v_r, wait_v_n;
  logic            ovr_r, ovr_n;
  logic            pop;
  logic            lose;
  logic            adv_en;

  assign adv_en = push_i | start_i | pop_req_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_n[i] = q_r[i];
    cnt_n    = cnt_r;
    wait_n   = wait_r;
    wait_v_n = wait_v_r;
    ovr_n    = ovr_r;
    lose     = 1'b0;
    pop      = pop_req_i && (cnt_r != '0);

    // 1: remove the head, shift the rest forward
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) q_n[i] = q_r[i + 1];
      cnt_n = cnt_r - 1'b1;
    end

    // 2: the waiting character enters the freed slot on the same edge
    if (wait_v_n && (cnt_n < FULL)) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == cnt_n) q_n[i] = wait_r;
      cnt_n    = cnt_n + 1'b1;
      wait_v_n = 1'b0;
    end

    // 3: a start bit while a character still waits destroys it
    if (start_i && wait_v_n) begin
      wait_v_n = 1'b0;
      lose     = 1'b1;
    end

    // 4: a newly completed character goes to the queue or waits
    if (push_i) begin
      if (cnt_n < FULL) begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_n) q_n[i] = push_ent_i;
        cnt_n = cnt_n + 1'b1;
      end else begin
        if (wait_v_n) lose = 1'b1;
        wait_n   = push_ent_i;
        wait_v_n = 1'b1;
      end
    end

    if (lose)     ovr_n = 1'b1;
    else if (pop) ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q_r[i] <= '0;
      cnt_r    <= '0;
      wait_r   <= '0;
      wait_v_r <= 1'b0;
      ovr_r    <= 1'b0;
    end else if (adv_en) begin
      for (int i = 0; i < DEPTH; i++) q_r[i] <= q_n[i];
      cnt_r    <= cnt_n;
      wait_r   <= wait_n;
      wait_v_r <= wait_v_n;
      ovr_r    <= ovr_n;
    end
  end

  assign head_valid_o = (cnt_r != '0);
  assign head_o       = head_valid_o ? q_r[0] : '0;
  assign ovr_o        = ovr_r;

endmodule

// File: rtl/rxs_tx_hold.sv
module rxs_tx_hold
  import uart_rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              take_i,
  input  logic              frame_done_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [CHAR_W-1:0] hold_o,
  output logic              hold_valid_o,
  output logic              txc_o
);

  localparam logic [STAT_W-1:0] TXC_MASK = STAT_W'(1) << ST_TXC;

  logic [CHAR_W-1:0] hold_r;
  logic              valid_r, valid_n;
  logic              txc_r, txc_n;
  logic              txc_clr;
  logic              valid_en, txc_en;

  assign txc_clr = stat_wr_i && ((stat_wdata_i & TXC_MASK) != '0);

  always_comb begin
    valid_n = valid_r;
    if (wr_i)        valid_n = 1'b1;
    else if (take_i) valid_n = 1'b0;
    txc_n = txc_r;
    if (frame_done_i) txc_n = 1'b1;
    else if (txc_clr) txc_n = 1'b0;
  end

  assign valid_en = wr_i | take_i;
  assign txc_en   = frame_done_i | txc_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r  <= '0;
      valid_r <= 1'b0;
      txc_r   <= 1'b0;
    end else begin
      if (wr_i)     hold_r  <= wdata_i;
      if (valid_en) valid_r <= valid_n;
      if (txc_en)   txc_r   <= txc_n;
    end
  end

  assign hold_o       = hold_r;
  assign hold_valid_o = valid_r;
  assign txc_o        = txc_r;

endmodule

// File: rtl/rxs_status_pack.sv
module rxs_status_pack
  import uart_rxs_pkg::*;
(
  input  rx_entry_t         head_i,
  input  logic              head_valid_i,
  input  logic              ovr_i,
  input  logic              par_en_i,
  input  logic              hold_valid_i,
  input  logic              txc_i,
  input  logic              rxc_ie_i,
  input  logic              dre_ie_i,
  input  logic              txc_ie_i,
  output logic [STAT_W-1:0] status_o,
  output logic [7:0]        rx_data_o,
  output logic              irq_rxc_o,
  output logic              irq_dre_o,
  output logic              irq_txc_o
);

  logic dre;

  assign dre = ~hold_valid_i;

  always_comb begin
    status_o          = '0;
    status_o[ST_RXC]  = head_valid_i;
    status_o[ST_TXC]  = txc_i;
    status_o[ST_DRE]  = dre;
    status_o[ST_FERR] = head_valid_i & head_i.ferr;
    status_o[ST_OVR]  = ovr_i;
    status_o[ST_PERR] = head_valid_i & head_i.pbad & par_en_i;
    status_o[ST_RSVD] = 1'b0;
    status_o[ST_BIT8] = head_valid_i & head_i.data[CHAR_W-1];
  end

  assign rx_data_o = head_i.data[7:0];
  assign irq_rxc_o = head_valid_i & rxc_ie_i;
  assign irq_dre_o = dre & dre_ie_i;
  assign irq_txc_o = txc_i & txc_ie_i;

endmodule

// File: rtl/uart_rx_status_regs.sv
module uart_rx_status_regs
  import uart_rxs_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_done_i,
  input  logic [8:0]  rx_bits_i,
  input  logic        rx_stop1_i,
  input  logic        rx_par_bad_i,
  input  logic        rx_start_i,
  input  logic        par_en_i,
  input  logic        rxc_ie_i,
  input  logic        dre_ie_i,
  input  logic        txc_ie_i,
  input  logic        data_rd_i,
  input  logic        data_wr_i,
  input  logic [8:0]  data_wdata_i,
  input  logic        stat_wr_i,
  input  logic [7:0]  stat_wdata_i,
  input  logic        tx_take_i,
  input  logic        tx_frame_done_i,
  output logic [7:0]  status_o,
  output logic [7:0]  rx_data_o,
  output logic [8:0]  tx_hold_o,
  output logic        tx_hold_valid_o,
  output logic        irq_rxc_o,
  output logic        irq_dre_o,
  output logic        irq_txc_o
);

  logic [1:0] rst_sync_r;
  logic       rst_int_n;
  rx_entry_t  new_ent;
  rx_entry_t  head;
  logic       head_valid;
  logic       ovr;
  logic       txc;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_int_n = rst_sync_r[1];

  assign new_ent.data = rx_bits_i;
  assign new_ent.ferr = ~rx_stop1_i;
  assign new_ent.pbad = rx_par_bad_i;

  rxs_char_queue #(.DEPTH(RX_DEPTH)) u_queue (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .push_i       (rx_done_i),
    .push_ent_i   (new_ent),
    .start_i      (rx_start_i),
    .pop_req_i    (data_rd_i),
    .head_o       (head),
    .head_valid_o (head_valid),
    .ovr_o        (ovr)
  );

  rxs_tx_hold u_txhold (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_i         (data_wr_i),
    .wdata_i      (data_wdata_i),
    .take_i       (tx_take_i),
    .frame_done_i (tx_frame_done_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .hold_o       (tx_hold_o),
    .hold_valid_o (tx_hold_valid_o),
    .txc_o        (txc)
  );

  rxs_status_pack u_pack (
    .head_i       (head),
    .head_valid_i (head_valid),
    .ovr_i        (ovr),
    .par_en_i     (par_en_i),
    .hold_valid_i (tx_hold_valid_o),
    .txc_i        (txc),
    .rxc_ie_i     (rxc_ie_i),
    .dre_ie_i     (dre_ie_i),
    .txc_ie_i     (txc_ie_i),
    .status_o     (status_o),
    .rx_data_o    (rx_data_o),
    .irq_rxc_o    (irq_rxc_o),
    .irq_dre_o    (irq_dre_o),
    .irq_txc_o    (irq_txc_o)
  );

endmodule

// File: rtl/uart_rxs_checker.sv
module uart_rxs_checker (
  input logic clk,
  input logic rst_int_n,
  input logic rx_done_i,
  input logic rx_start_i,
  input logic data_wr_i,
  input logic stat_wr_i,
  input logic stat_wbit6,
  input logic tx_frame_done_i,
  input logic par_en_i,
  input logic dre_ie_i,
  input logic st_rxc,
  input logic st_txc,
  input logic st_dre,
  input logic st_ovr,
  input logic st_perr,
  input logic irq_dre_o
);

  // R2
  dre_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_wr_i |=> !st_dre);

  // R3
  dre_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_dre_o == (st_dre && dre_ie_i));

  // R6
  perr_gated_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !par_en_i |-> !st_perr);

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(st_ovr) |-> $past(rx_start_i || rx_done_i));

  // R9
  rxc_after_char_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_done_i |=> st_rxc);

  // R10
  txc_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_frame_done_i |=> st_txc);

  // R11
  txc_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_wr_i && !stat_wbit6 && st_txc) |=> st_txc);

endmodule

bind uart_rx_status_regs uart_rxs_checker u_rxs_checker (
  .clk             (clk),
  .rst_int_n       (rst_int_n),
  .rx_done_i       (rx_done_i),
  .rx_start_i      (rx_start_i),
  .data_wr_i       (data_wr_i),
  .stat_wr_i       (stat_wr_i),
  .stat_wbit6      (stat_wdata_i[6]),
  .tx_frame_done_i (tx_frame_done_i),
  .par_en_i        (par_en_i),
  .dre_ie_i        (dre_ie_i),
  .st_rxc          (status_o[7]),
  .st_txc          (status_o[6]),
  .st_dre          (status_o[5]),
  .st_ovr          (status_o[3]),
  .st_perr         (status_o[2]),
  .irq_dre_o       (irq_dre_o)
);

// File: tb/test_uart_rx_status_regs.sv
module test_uart_rx_status_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_done_i = 0, rx_stop1_i = 0, rx_par_bad_i = 0, rx_start_i = 0;
  logic [8:0] rx_bits_i = '0;
  logic       par_en_i = 0, rxc_ie_i = 0, dre_ie_i = 0, txc_ie_i = 0;
  logic       data_rd_i = 0, data_wr_i = 0, stat_wr_i = 0;
  logic [8:0] data_wdata_i = '0;
  logic [7:0] stat_wdata_i = '0;
  logic       tx_take_i = 0, tx_frame_done_i = 0;
  logic [7:0] status_o, rx_data_o;
  logic [8:0] tx_hold_o;
  logic       tx_hold_valid_o, irq_rxc_o, irq_dre_o, irq_txc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_status_regs i_uart_rx_status_regs (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(bit rxc, bit txc, bit dre, bit fe,
                                    bit ov, bit pe, bit b8);
    return {rxc, txc, dre, fe, ov, pe, 1'b0, b8};
  endfunction

  task automatic put(logic [8:0] d, bit stop1, bit pbad);
    rx_bits_i = d; rx_stop1_i = stop1; rx_par_bad_i = pbad; rx_done_i = 1;
    tick();
    rx_done_i = 0;
  endtask

  task automatic rd();
    data_rd_i = 1;
    tick();
    data_rd_i = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    chk("R1", status_o, 8'h20);
    chk("R1", {irq_rxc_o, irq_dre_o, irq_txc_o}, 3'b000);
    dre_ie_i = 1; #1;
    chk("R3", irq_dre_o, 1);

    // R2/R3 holding register
    data_wdata_i = 9'h1A5; data_wr_i = 1; tick(); data_wr_i = 0;
    chk("R2", status_o[5], 0);
    chk("R2", {tx_hold_valid_o, tx_hold_o}, {1'b1, 9'h1A5});
    chk("R3", irq_dre_o, 0);
    tx_take_i = 1; tick(); tx_take_i = 0;
    chk("R2", status_o[5], 1);
    chk("R3", irq_dre_o, 1);
    tick();
    chk("R3", irq_dre_o, 1);
    data_wdata_i = 9'h033; data_wr_i = 1; tick(); data_wr_i = 0;
    data_wdata_i = 9'h0C4; data_wr_i = 1; tx_take_i = 1; tick();
    data_wr_i = 0; tx_take_i = 0;
    chk("R2", {status_o[5], tx_hold_o}, {1'b0, 9'h0C4});
    tx_take_i = 1; tick(); tx_take_i = 0;
    chk("R2", status_o[5], 1);
    dre_ie_i = 0; #1;
    chk("R3", irq_dre_o, 0);

    // R10/R11 transmit complete and status writes
    tx_frame_done_i = 1; tick(); tx_frame_done_i = 0;
    chk("R10", status_o, st(0, 1, 1, 0, 0, 0, 0));
    chk("R10", irq_txc_o, 0);
    txc_ie_i = 1; #1;
    chk("R10", irq_txc_o, 1);
    stat_wdata_i = 8'hBF; stat_wr_i = 1; tick(); stat_wr_i = 0;
    chk("R11", status_o, st(0, 1, 1, 0, 0, 0, 0));
    stat_wdata_i = 8'h40; stat_wr_i = 1; tick(); stat_wr_i = 0;
    chk("R10", status_o, 8'h20);
    chk("R10", irq_txc_o, 0);

    // R4/R5/R6/R9 sweep over tags and parity enable
    for (int i = 0; i < 32; i++) begin
      logic [8:0] da, db;
      bit sa, sb, pa, pb, pe;
      da = {i[0], 8'(i * 37 + 5)};
      db = {~i[0], 8'(i * 11 + 3)};
      sa = i[1]; sb = i[4]; pa = i[2]; pb = ~i[2]; pe = i[3];
      par_en_i = pe; rxc_ie_i = i[0];
      put(da, sa, pa);
      put(db, sb, pb);
      chk("R4", rx_data_o, da[7:0]);
      chk("R5", status_o, st(1, 0, 1, ~sa, 0, pa & pe, da[8]));
      chk("R9", irq_rxc_o, i[0]);
      rd();
      chk("R4", rx_data_o, db[7:0]);
      chk("R6", status_o, st(1, 0, 1, ~sb, 0, pb & pe, db[8]));
      rd();
      chk("R9", status_o, 8'h20);
      chk("R9", irq_rxc_o, 0);
    end
    par_en_i = 0; rxc_ie_i = 0;

    // R12 read while empty
    rd();
    chk("R12", status_o, 8'h20);
    put(9'h155, 1, 0);
    chk("R12", {status_o, rx_data_o}, {st(1, 0, 1, 0, 0, 0, 1), 8'h55});
    rd();
    chk("R12", status_o[7], 0);

    // R7 waiting character moves in on read
    put(9'h011, 1, 0); put(9'h022, 0, 0); put(9'h133, 1, 0);
    chk("R7", {status_o, rx_data_o}, {st(1, 0, 1, 0, 0, 0, 0), 8'h11});
    rd();
    chk("R7", {status_o, rx_data_o}, {st(1, 0, 1, 1, 0, 0, 0), 8'h22});
    rd();
    chk("R7", {status_o, rx_data_o}, {st(1, 0, 1, 0, 0, 0, 1), 8'h33});
    rd();
    chk("R7", status_o[7], 0);

    // R8 overrun on start bit
    put(9'h041, 1, 0); put(9'h042, 1, 0); put(9'h043, 1, 0);
    rx_start_i = 1; tick(); rx_start_i = 0;
    chk("R8", {status_o, rx_data_o}, {st(1, 0, 1, 0, 1, 0, 0), 8'h41});
    rd();
    chk("R8", {status_o, rx_data_o}, {st(1, 0, 1, 0, 0, 0, 0), 8'h42});
    rd();
    chk("R8", status_o, 8'h20);

    // R8 read and start in the same cycle: read wins
    put(9'h051, 1, 0); put(9'h052, 1, 0); put(9'h053, 1, 0);
    rx_start_i = 1; data_rd_i = 1; tick(); rx_start_i = 0; data_rd_i = 0;
    chk("R8", {status_o, rx_data_o}, {st(1, 0, 1, 0, 0, 0, 0), 8'h52});
    rd();
    chk("R8", rx_data_o, 8'h53);
    rd();
    chk("R8", status_o, 8'h20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule